// File: doc/BRIEF.md
# DRAM Opportunistic Refresh Controller

This block decides when a DRAM array gets CAS-before-RAS refresh cycles. It does not use a fixed refresh timer. It watches the local bus every clock. Whenever no master is asking for the DRAM, it starts a refresh. That covers an empty bus and also a cycle whose address lies below the DRAM window. Each refresh lowers the column strobe first, then the row strobe, holds both for a set time, then releases both and honours a precharge gap. The refreshed row comes from an internal rotating counter that mirrors the counter inside the DRAM.

A DRAM request that arrives while a refresh is running is stalled with a wait signal until the precharge has finished. A request that arrives while the sequencer is idle is granted at once. Granted accesses also count as refresh of the row they open, so sequential traffic that touches every row keeps the array fresh without any refresh cycles at all.

A coverage tracker records which rows have been refreshed or opened in the current window. It reports one pulse when every row has been covered. It reports a violation pulse when a fixed number of clocks passes without full coverage. Either pulse starts a new window.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and just after it, both strobes are high (inactive) and `bus_wait`, `sweep_done` and `refresh_violation` are low.
- R2: A refresh cycle drives `dram_cas_n` low alone for exactly CAS_LEAD clocks. Both strobes are then low for exactly RAS_HOLD clocks, and both rise in the same clock; the row strobe is never low while the column strobe is high.
- R3: With no DRAM request, refresh cycles run back to back with both strobes high for exactly PRECHARGE clocks between them.
- R4: A bus cycle whose address is below WINDOW_BASE is treated as idle: refresh keeps running as in R3 and `bus_wait` stays low.
- R5: A DRAM request (`bus_valid` high and address at or above WINDOW_BASE) seen while a refresh is in progress gets `bus_wait` high until the precharge of that refresh has ended. For a request raised in the first column-lead clock that is CAS_LEAD+RAS_HOLD+PRECHARGE clocks, and the request is granted in the next clock with `bus_wait` low. `bus_wait` is never high without a DRAM request.
- R6: While a DRAM request is present and the sequencer is idle or finishing precharge, no new refresh begins (`dram_cas_n` stays high).
- R7: Each refresh covers the next row of an internal rotating row counter. With only refresh cycles, exactly 2^ROW_W refresh cycles separate two consecutive `sweep_done` pulses.
- R8: A granted DRAM access covers the row held in address bits [ROW_LSB +: ROW_W]; address bits above that field are ignored. When the granted rows in a window cover all 2^ROW_W rows, in any order, `sweep_done` pulses high for one clock in the clock after the completing grant. An unbroken run of grants through any permutation of the rows gives one pulse every 2^ROW_W clocks.
- R9: If INTERVAL clocks pass in a window without full coverage, `refresh_violation` pulses high for one clock and a new window starts. Under a steady stall on one row, the pulses are exactly INTERVAL clocks apart. `sweep_done` and `refresh_violation` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus master drives a cycle this clock |
| bus_addr | input | ADDR_W | Address of the current bus cycle |
| bus_wait | output | 1 | Stall for a DRAM request while refresh owns the array |
| dram_cas_n | output | 1 | Column strobe to the DRAM, active low |
| dram_ras_n | output | 1 | Row strobe to the DRAM, active low |
| sweep_done | output | 1 | One-clock pulse: every row covered in this window |
| refresh_violation | output | 1 | One-clock pulse: window expired without full coverage |

## Verification
A wrong sequencer count shows at once on the strobes as a column-lead, hold or precharge run of the wrong length. It also shows in the exact number of `bus_wait` clocks a stalled request sees. A fault in the row bitmap or the refresh row counter only shows at the end of a window: `sweep_done` arrives early, late or never, or `refresh_violation` fires when full coverage was reached. The bench therefore measures pulse spacing over several windows. It drives permuted sweeps of every row, a refresh-only run and a single-row stall, so that a coverage error becomes visible within one or two windows.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_ACTIVE,
        SEQ_PRECHG
    } seq_state_e;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/refresh_seq.sv
module refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int CAS_LEAD  = 1,
    parameter int RAS_HOLD  = 3,
    parameter int PRECHARGE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    output logic busy,
    output logic cas_n,
    output logic ras_n,
    output logic row_done
);
    localparam int LONGEST = max_of3(CAS_LEAD, RAS_HOLD, PRECHARGE);
    localparam int CNT_W   = $clog2(LONGEST + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        d        = q;
        row_done = 1'b0;
        case (q.st)
            SEQ_IDLE: begin
                if (start_ok) begin
                    d.st  = SEQ_LEAD;
                    d.cnt = CNT_W'(CAS_LEAD - 1);
                end
            end
            SEQ_LEAD: begin
                if (q.cnt == '0) begin
                    d.st  = SEQ_ACTIVE;
                    d.cnt = CNT_W'(RAS_HOLD - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SEQ_ACTIVE: begin
                if (q.cnt == '0) begin
                    d.st     = SEQ_PRECHG;
                    d.cnt    = CNT_W'(PRECHARGE - 1);
                    row_done = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SEQ_PRECHG: begin
                if (q.cnt == '0) begin
                    if (start_ok) begin
                        d.st  = SEQ_LEAD;
                        d.cnt = CNT_W'(CAS_LEAD - 1);
                    end else begin
                        d.st = SEQ_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= SEQ_IDLE;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy  = (q.st != SEQ_IDLE);
    assign cas_n = !((q.st == SEQ_LEAD) || (q.st == SEQ_ACTIVE));
    assign ras_n = !(q.st == SEQ_ACTIVE);

endmodule

// File: rtl/row_tracker.sv
module row_tracker #(
    parameter int ROW_W    = 8,
    parameter int INTERVAL = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_hit,
    input  logic [ROW_W-1:0] acc_row,
    input  logic             ref_hit,
    output logic             sweep_done,
    output logic             violation
);
    localparam int ROWS = 1 << ROW_W;
    localparam int WD_W = $clog2(INTERVAL);

    typedef struct packed {
        logic [ROWS-1:0]  seen;
        logic [WD_W-1:0]  wd;
        logic [ROW_W-1:0] ref_row;
        logic             done;
        logic             viol;
    } trk_regs_t;

    trk_regs_t       q, d;
    logic [ROWS-1:0] marks;
    logic [ROWS-1:0] merged;

    always_comb begin
        d      = q;
        marks  = '0;
        if (acc_hit) marks = marks | (ROWS'(1) << acc_row);
        if (ref_hit) begin
            marks     = marks | (ROWS'(1) << q.ref_row);
            d.ref_row = q.ref_row + 1'b1;
        end
        merged = q.seen | marks;
        d.done = 1'b0;
        d.viol = 1'b0;
        if (&merged) begin
            d.seen = '0;
            d.wd   = '0;
            d.done = 1'b1;
        end else if (q.wd == WD_W'(INTERVAL - 1)) begin
            d.seen = '0;
            d.wd   = '0;
            d.viol = 1'b1;
        end else begin
            d.seen = merged;
            d.wd   = q.wd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sweep_done = q.done;
    assign violation  = q.viol;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int          ADDR_W      = 16,
    parameter int          ROW_W       = 8,
    parameter int          ROW_LSB     = 0,
    parameter int unsigned WINDOW_BASE = 32'h1000,
    parameter int          CAS_LEAD    = 1,
    parameter int          RAS_HOLD    = 3,
    parameter int          PRECHARGE   = 2,
    parameter int          INTERVAL    = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wait,
    output logic              dram_cas_n,
    output logic              dram_ras_n,
    output logic              sweep_done,
    output logic              refresh_violation
);
    logic             dram_req;
    logic             seq_busy;
    logic             row_done;
    logic             grant;
    logic [ROW_W-1:0] acc_row;

    assign dram_req = bus_valid && (bus_addr >= ADDR_W'(WINDOW_BASE));
    assign bus_wait = dram_req && seq_busy;
    assign grant    = dram_req && !seq_busy;
    assign acc_row  = bus_addr[ROW_LSB +: ROW_W];

    refresh_seq #(
        .CAS_LEAD (CAS_LEAD),
        .RAS_HOLD (RAS_HOLD),
        .PRECHARGE(PRECHARGE)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_ok(!dram_req),
        .busy    (seq_busy),
        .cas_n   (dram_cas_n),
        .ras_n   (dram_ras_n),
        .row_done(row_done)
    );

    row_tracker #(
        .ROW_W   (ROW_W),
        .INTERVAL(INTERVAL)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_hit   (grant),
        .acc_row   (acc_row),
        .ref_hit   (row_done),
        .sweep_done(sweep_done),
        .violation (refresh_violation)
    );

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
    parameter int          ADDR_W      = 16,
    parameter int unsigned WINDOW_BASE = 32'h1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wait,
    input logic              dram_cas_n,
    input logic              dram_ras_n,
    input logic              sweep_done,
    input logic              refresh_violation
);
    logic dram_req;
    assign dram_req = bus_valid && (bus_addr >= ADDR_W'(WINDOW_BASE));

    assert_cas_leads_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (!dram_cas_n && $past(!dram_cas_n)));

    assert_release_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> $rose(dram_ras_n));

    assert_precharge_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |=> (dram_ras_n && dram_cas_n));

    assert_wait_needs_dram_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> dram_req);

    assert_no_refresh_on_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_req && dram_cas_n) |=> dram_cas_n);

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sweep_done && refresh_violation));

endmodule

bind dram_refresh_sched dram_refresh_chk #(
    .ADDR_W     (ADDR_W),
    .WINDOW_BASE(WINDOW_BASE)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_valid        (bus_valid),
    .bus_addr         (bus_addr),
    .bus_wait         (bus_wait),
    .dram_cas_n       (dram_cas_n),
    .dram_ras_n       (dram_ras_n),
    .sweep_done       (sweep_done),
    .refresh_violation(refresh_violation)
);

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
    localparam int ADDR_W   = 16;
    localparam int ROW_W    = 3;
    localparam int ROWS     = 1 << ROW_W;
    localparam int CAS_LEAD = 2;
    localparam int RAS_HOLD = 3;
    localparam int PRE      = 2;
    localparam int INTERVAL = 64;
    localparam int BASE     = 32'h1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wait, dram_cas_n, dram_ras_n, sweep_done, refresh_violation;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .ROW_LSB(0), .WINDOW_BASE(BASE),
        .CAS_LEAD(CAS_LEAD), .RAS_HOLD(RAS_HOLD), .PRECHARGE(PRE), .INTERVAL(INTERVAL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_wait(bus_wait), .dram_cas_n(dram_cas_n), .dram_ras_n(dram_ras_n),
        .sweep_done(sweep_done), .refresh_violation(refresh_violation)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    // Watch strobe runs: R2 lead/hold lengths, R3 gap, R4 no wait, R7 refreshes per sweep
    task automatic watch_strobes(input int n, input bit no_viol, input string tag);
        int  lead = 0, hold = 0, hi = 0, falls = 0, waits = 0, viols = 0, illegal = 0, pairs = 0;
        bit  lead_ok = 0, hold_ok = 0, hi_ok = 0, seen_sw = 0;
        logic pc, pr;
        pc = dram_cas_n;
        pr = dram_ras_n;
        for (int i = 0; i < n; i++) begin
            step();
            if (dram_cas_n && !dram_ras_n) illegal++;
            if (pc && pr && !dram_cas_n && dram_ras_n) begin
                if (hi_ok) check(hi == PRE, "R3", {tag, " precharge gap"}, hi, PRE);
                lead = 1; lead_ok = 1;
            end else if (!dram_cas_n && dram_ras_n) lead++;
            if (!pc && pr && !dram_cas_n && !dram_ras_n) begin
                if (lead_ok) check(lead == CAS_LEAD, "R2", {tag, " cas lead"}, lead, CAS_LEAD);
                hold = 1; hold_ok = 1; falls++;
            end else if (!dram_cas_n && !dram_ras_n) hold++;
            if (!pc && !pr && dram_cas_n && dram_ras_n) begin
                if (hold_ok) check(hold == RAS_HOLD, "R2", {tag, " ras hold"}, hold, RAS_HOLD);
                hi = 1; hi_ok = 1;
            end else if (dram_cas_n && dram_ras_n) hi++;
            if (refresh_violation) begin
                viols++; seen_sw = 0; falls = 0;
            end
            if (sweep_done) begin
                if (seen_sw) begin
                    check(falls == ROWS, "R7", {tag, " refreshes per sweep"}, falls, ROWS);
                    pairs++;
                end
                seen_sw = 1; falls = 0;
            end
            if (bus_wait) waits++;
            pc = dram_cas_n;
            pr = dram_ras_n;
        end
        check(illegal == 0, "R2", {tag, " ras low with cas high"}, illegal, 0);
        check(waits == 0, "R4", {tag, " wait cycles"}, waits, 0);
        check(pairs >= 1, "R7", {tag, " sweep pairs seen"}, pairs, 1);
        if (no_viol) check(viols == 0, "R9", {tag, " violations"}, viols, 0);
    endtask

    // Sweep of all rows through granted accesses: mode 0 ascending, 1 descending, 2 stride 3
    task automatic sweep_run(input int base, input int mode, input string tag);
        int t[8];
        int np = 0, idx = 0, viols = 0, row = 0;
        bus_valid = 1'b1;
        for (int c = 0; c < ROWS * 5 + 10; c++) begin
            case (mode)
                0: row = idx % ROWS;
                1: row = ROWS - 1 - (idx % ROWS);
                default: row = (idx * 3) % ROWS;
            endcase
            bus_addr = ADDR_W'(base + row);
            #0.5;
            if (!bus_wait) idx++;
            if (sweep_done && np < 8) begin
                t[np] = c; np++;
            end
            if (refresh_violation) viols++;
            step();
        end
        check(np >= 4, "R8", {tag, " sweep pulses"}, np, 4);
        if (np >= 4) begin
            check(t[2] - t[1] == ROWS, "R8", {tag, " sweep spacing a"}, t[2] - t[1], ROWS);
            check(t[3] - t[2] == ROWS, "R8", {tag, " sweep spacing b"}, t[3] - t[2], ROWS);
        end
        check(viols == 0, "R9", {tag, " violations during sweep"}, viols, 0);
    endtask

    initial begin
        // R1 reset state
        repeat (3) step();
        check(dram_cas_n && dram_ras_n, "R1", "strobes in reset", {dram_cas_n, dram_ras_n}, 3);
        check(!bus_wait && !sweep_done && !refresh_violation, "R1", "flags in reset",
              {bus_wait, sweep_done, refresh_violation}, 0);
        rst_n = 1'b1;
        #0.5;
        check(dram_cas_n && dram_ras_n, "R1", "strobes after reset", {dram_cas_n, dram_ras_n}, 3);

        // R2 R3 R7: idle bus, refresh only
        watch_strobes(200, 1'b1, "idle");

        // R5: DRAM request raised in the first lead clock
        begin
            logic prev;
            int   nw = 0;
            do begin
                prev = dram_cas_n;
                step();
            end while (!(prev && !dram_cas_n && dram_ras_n));
            bus_valid = 1'b1;
            bus_addr  = 16'h1003;
            #0.5;
            while (bus_wait && nw < 50) begin
                nw++;
                step();
                #0.5;
            end
            check(nw == CAS_LEAD + RAS_HOLD + PRE, "R5", "wait clocks", nw, CAS_LEAD + RAS_HOLD + PRE);
            check(dram_cas_n && dram_ras_n && !bus_wait, "R5", "granted after precharge",
                  {dram_cas_n, dram_ras_n, bus_wait}, 6);
        end

        // R6: request held, no refresh may start
        begin
            int lows = 0;
            for (int i = 0; i < 30; i++) begin
                step();
                if (!dram_cas_n || bus_wait) lows++;
            end
            check(lows == 0, "R6", "refresh started under request", lows, 0);
        end

        // R8: permuted sweeps, upper address bits ignored
        sweep_run(32'h1000, 0, "ascending");
        sweep_run(32'h1000, 1, "descending");
        sweep_run(32'h7ff0 & 32'hfff8, 2, "stride3 high page");

        // R9: steady stall on one row
        begin
            int t0 = -1, t1 = -1, wide = 0, sw = 0, lowras = 0;
            bus_valid = 1'b1;
            bus_addr  = 16'h1002;
            for (int c = 0; c < 200; c++) begin
                step();
                if (refresh_violation) begin
                    if (t0 < 0) t0 = c;
                    else if (t1 < 0) t1 = c;
                    if (c > 0 && t0 == c - 1) wide++;
                end
                if (sweep_done) sw++;
                if (!dram_ras_n) lowras++;
            end
            check(t0 >= 0 && t1 >= 0, "R9", "two violations seen", (t1 >= 0), 1);
            check(t1 - t0 == INTERVAL, "R9", "violation spacing", t1 - t0, INTERVAL);
            check(wide == 0, "R9", "violation pulse width", wide, 0);
            check(sw == 0, "R8", "sweep on single row", sw, 0);
            check(lowras == 0, "R6", "ras under stall", lowras, 0);
        end

        // R4: address just below the window behaves as idle
        bus_valid = 1'b1;
        bus_addr  = 16'h0fff;
        watch_strobes(200, 1'b0, "below window");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule